// File: doc/BRIEF.md
# Carrier Detect Qualifier with Release Hysteresis

This block sits between the band filter's amplitude detector and the byte receiver of a frequency-shift-keyed data front end. It takes one activity flag per clock and drives an active-low carrier indication. Stray bursts of energy do not assert that indication. Time is cut into fixed windows, and a window counts as active when at least one activity sample falls inside it. Carrier is declared only when enough of the most recent windows were active.

Once declared, carrier is held through short gaps in activity. It is withdrawn only after an unbroken stretch of quiet clocks of a fixed length. Any single activity sample restarts that stretch. On release, the window history is wiped, so a new declaration needs a full set of fresh active windows.

The same carrier state gates the byte receiver through a load enable. It also shapes the three serial interface pins according to the selected interface mode. In the push mode, all three pins are held high while carrier is absent. In the host-clocked mode, only the ready strobe is held high, and the receiver is kept from loading.

Top module: `cdq_top`

## Requirements
- R1: While reset is held and after its release with no activity, `cd_n_o` is 1 and `rx_en_o` is 0; with `mode_i`=0, `data_o`, `dclk_o` and `rdy_n_o` are 1.
- R2: Clocks are grouped into windows of `WIN_CYC` clocks, starting from the release of the internal reset. A window is marked active when `act_i` is 1 on at least one of its clocks. The mark is pushed into an `M_WIN`-deep history at the window's last clock.
- R3: `cd_n_o` falls one clock after the history holds at least `N_HIT` active marks. It never falls while fewer than `N_HIT` marks are present.
- R4: While carrier is present, a clock with `act_i`=1 keeps it present. A run of fewer than `HOLD_CYC` consecutive quiet clocks does not release it.
- R5: After `HOLD_CYC` consecutive clocks with `act_i`=0, `cd_n_o` rises at the edge of the last quiet clock. The same edge empties the history and restarts window timing.
- R6: `rx_en_o` is 1 exactly when carrier is present (`cd_n_o`=0), in both modes.
- R7: With `mode_i`=0 and no carrier, `data_o`, `dclk_o` and `rdy_n_o` are 1. With carrier, they equal `rx_data_i`, `rx_dclk_i` and `rx_rdy_n_i`.
- R8: With `mode_i`=1 and no carrier, `rdy_n_o` is 1, while `data_o` and `dclk_o` follow `rx_data_i` and `rx_dclk_i`. With carrier, all three follow their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_i | input | 1 | Per-clock activity flag from the band filter detector |
| mode_i | input | 1 | Interface mode: 0 push mode, 1 host-clocked mode |
| rx_data_i | input | 1 | Serial data from the byte receiver |
| rx_dclk_i | input | 1 | Bit clock from the byte receiver (push mode) |
| rx_rdy_n_i | input | 1 | Active-low byte-ready strobe from the byte receiver |
| cd_n_o | output | 1 | Carrier detect, low while carrier is present |
| rx_en_o | output | 1 | Load enable for the byte receiver, high with carrier |
| data_o | output | 1 | Serial data pin after carrier gating |
| dclk_o | output | 1 | Bit clock pin after carrier gating |
| rdy_n_o | output | 1 | Ready strobe pin after carrier gating |

## Verification
Release and history update can land on the same clock in two ways. The quiet counter can reach its limit on a window's last clock. A single activity sample can also arrive on exactly the clock the release would happen. The first case is provoked by sweeping every pattern of active windows and then letting the line go quiet until release. The second is provoked by sweeping gap lengths around `HOLD_CYC`, both one short and exactly equal. A cycle-accurate reference computed in the bench from the window and gap rules judges every clock. Directed checks then confirm that a gap one clock short of the limit keeps carrier, and that a gap of exactly the limit drops it.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  typedef enum logic {
    IF_PUSH = 1'b0,
    IF_HOST = 1'b1
  } if_mode_e;

  typedef enum logic {
    CAR_OFF = 1'b0,
    CAR_ON  = 1'b1
  } car_state_e;

  typedef struct packed {
    logic data;
    logic dclk;
    logic rdy_n;
  } ser_pins_t;

endpackage

// File: rtl/cdq_rst_sync.sv
module cdq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= 1'b1;
      end
      assign rst_sync_n = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      logic [STAGES-1:0] stg_d;
      always_comb begin
        stg_d = {stg_q[STAGES-2:0], 1'b1};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
      end
      assign rst_sync_n = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cdq_window.sv
module cdq_window #(
  parameter int WIN_CYC = 50000,
  parameter int M_WIN   = 10,
  parameter int N_HIT   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic clr_i,
  output logic qual_o
);

  localparam int WC_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int CNT_W = $clog2(M_WIN + 1);
  localparam logic [WC_W-1:0]  WC_LAST = WC_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] HIT_MIN = CNT_W'(N_HIT);

  logic [WC_W-1:0]  wc_q, wc_d;
  logic             hit_q, hit_d;
  logic [M_WIN-1:0] hist_q, hist_d;
  logic             win_end;
  logic             win_mark;
  logic [CNT_W-1:0] ones;

  always_comb begin
    win_end  = (wc_q == WC_LAST);
    win_mark = hit_q | act_i;
    wc_d     = wc_q;
    hit_d    = hit_q;
    hist_d   = hist_q;
    if (clr_i) begin
      wc_d   = '0;
      hit_d  = 1'b0;
      hist_d = '0;
    end else if (win_end) begin
      wc_d   = '0;
      hit_d  = 1'b0;
      hist_d = {hist_q[M_WIN-2:0], win_mark};
    end else begin
      wc_d   = wc_q + WC_W'(1);
      hit_d  = win_mark;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q   <= '0;
      hit_q  <= 1'b0;
      hist_q <= '0;
    end else begin
      wc_q   <= wc_d;
      hit_q  <= hit_d;
      hist_q <= hist_d;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < M_WIN; i++) begin
      ones = ones + CNT_W'(hist_q[i]);
    end
    qual_o = (ones >= HIT_MIN);
  end

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (hist_q == '0) && !hit_q);

  p_window_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wc_q <= WC_LAST);

endmodule

// File: rtl/cdq_hold.sv
module cdq_hold
  import cdq_pkg::*;
#(
  parameter int HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic qual_i,
  output logic car_o,
  output logic rel_o
);

  localparam int QW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(HOLD_CYC - 1);

  car_state_e    st_q, st_d;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          quiet_en;

  always_comb begin
    st_d     = st_q;
    quiet_d  = quiet_q;
    quiet_en = 1'b0;
    rel_o    = 1'b0;
    case (st_q)
      CAR_OFF: begin
        quiet_d  = '0;
        quiet_en = 1'b1;
        if (qual_i) st_d = CAR_ON;
      end
      CAR_ON: begin
        quiet_en = 1'b1;
        if (act_i) begin
          quiet_d = '0;
        end else if (quiet_q == Q_LAST) begin
          quiet_d = '0;
          st_d    = CAR_OFF;
          rel_o   = 1'b1;
        end else begin
          quiet_d = quiet_q + QW'(1);
        end
      end
      default: st_d = CAR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CAR_OFF;
      quiet_q <= '0;
    end else begin
      st_q <= st_d;
      if (quiet_en) quiet_q <= quiet_d;
    end
  end

  assign car_o = (st_q == CAR_ON);

  p_act_keeps_carrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (car_o && act_i) |=> car_o);

  p_quiet_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    car_o |-> (quiet_q <= Q_LAST));

  p_quiet_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(car_o) |-> (quiet_q == '0));

endmodule

// File: rtl/cdq_gate.sv
module cdq_gate
  import cdq_pkg::*;
(
  input  if_mode_e  mode_i,
  input  logic      car_i,
  input  ser_pins_t rx_i,
  output ser_pins_t pin_o,
  output logic      ld_en_o
);

  always_comb begin
    pin_o   = rx_i;
    ld_en_o = car_i;
    if (!car_i) begin
      case (mode_i)
        IF_PUSH: pin_o = '{data: 1'b1, dclk: 1'b1, rdy_n: 1'b1};
        IF_HOST: pin_o.rdy_n = 1'b1;
        default: pin_o = '{data: 1'b1, dclk: 1'b1, rdy_n: 1'b1};
      endcase
    end
  end

endmodule

// File: rtl/cdq_top.sv
module cdq_top
  import cdq_pkg::*;
#(
  parameter int WIN_CYC     = 50000,
  parameter int M_WIN       = 10,
  parameter int N_HIT       = 8,
  parameter int HOLD_CYC    = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic mode_i,
  input  logic rx_data_i,
  input  logic rx_dclk_i,
  input  logic rx_rdy_n_i,
  output logic cd_n_o,
  output logic rx_en_o,
  output logic data_o,
  output logic dclk_o,
  output logic rdy_n_o
);

  logic      rst_sync_n;
  logic      qual;
  logic      car;
  logic      rel;
  ser_pins_t rx_pins;
  ser_pins_t out_pins;
  if_mode_e  mode;

  cdq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdq_window #(.WIN_CYC(WIN_CYC), .M_WIN(M_WIN), .N_HIT(N_HIT)) u_win (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act_i  (act_i),
    .clr_i  (rel),
    .qual_o (qual)
  );

  cdq_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act_i  (act_i),
    .qual_i (qual),
    .car_o  (car),
    .rel_o  (rel)
  );

  always_comb begin
    rx_pins = '{data: rx_data_i, dclk: rx_dclk_i, rdy_n: rx_rdy_n_i};
    mode    = if_mode_e'(mode_i);
  end

  cdq_gate u_gate (
    .mode_i  (mode),
    .car_i   (car),
    .rx_i    (rx_pins),
    .pin_o   (out_pins),
    .ld_en_o (rx_en_o)
  );

  assign cd_n_o  = ~car;
  assign data_o  = out_pins.data;
  assign dclk_o  = out_pins.dclk;
  assign rdy_n_o = out_pins.rdy_n;

  p_no_early_assert_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cd_n_o && !qual) |=> cd_n_o);

  p_enable_tracks_cd_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_en_o == !cd_n_o);

  p_push_forced_high_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cd_n_o && !mode_i) |-> (data_o && dclk_o && rdy_n_o));

  p_host_ready_high_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cd_n_o && mode_i) |-> (rdy_n_o && (data_o == rx_data_i) && (dclk_o == rx_dclk_i)));

endmodule

// File: tb/test_cdq_top.sv
module test_cdq_top;

  localparam int W = 4;
  localparam int M = 5;
  localparam int N = 3;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0;
  logic mode = 1'b0;
  logic rxd = 1'b0, rxc = 1'b0, rxr = 1'b0;
  logic cd_n, en, d_o, c_o, r_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic model_on = 1'b0;

  always #10 clk = ~clk;

  cdq_top #(.WIN_CYC(W), .M_WIN(M), .N_HIT(N), .HOLD_CYC(H), .SYNC_STAGES(2)) i_cdq_top (
    .clk(clk), .rst_n(rst_n), .act_i(act), .mode_i(mode),
    .rx_data_i(rxd), .rx_dclk_i(rxc), .rx_rdy_n_i(rxr),
    .cd_n_o(cd_n), .rx_en_o(en), .data_o(d_o), .dclk_o(c_o), .rdy_n_o(r_o)
  );

  // reference computed from the window, history and gap rules
  logic ms1, ms2, mhit, mon;
  logic [M-1:0] mhist;
  int mwc, mq;

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic rel;
    if (!rst_n) begin
      ms1 <= 0; ms2 <= 0; mwc <= 0; mhit <= 0; mhist <= '0; mon <= 0; mq <= 0;
    end else begin
      ms1 <= 1'b1;
      ms2 <= ms1;
      if (ms2) begin
        rel = mon && !act && (mq == H - 1);
        if (!mon) begin
          mq <= 0;
          if ($countones(mhist) >= N) mon <= 1'b1;
        end else if (act) mq <= 0;
        else if (rel) begin mon <= 1'b0; mq <= 0; end
        else mq <= mq + 1;
        if (rel) begin mwc <= 0; mhit <= 0; mhist <= '0; end
        else if (mwc == W - 1) begin mwc <= 0; mhit <= 0; mhist <= {mhist[M-2:0], mhit | act}; end
        else begin mwc <= mwc + 1; mhit <= mhit | act; end
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (model_on) begin
      logic ed, ec, er;
      ed = (!mon && !mode) ? 1'b1 : rxd;
      ec = (!mon && !mode) ? 1'b1 : rxc;
      er = (!mon) ? 1'b1 : rxr;
      chk(cur_req, "cd_n", cd_n, !mon);
      chk("R6", "rx_en", en, mon);
      chk(mode ? "R8" : "R7", "pins", {d_o, c_o, r_o}, {ed, ec, er});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input logic a);
    @(negedge clk);
    act = a;
  endtask

  task automatic acquire();
    int guard = 0;
    while (cd_n !== 1'b0 && guard < 200) begin
      step(1'b1);
      #6;
      guard++;
    end
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    #6;
    chk("R1", "cd_n in reset", cd_n, 1);
    chk("R1", "rx_en in reset", en, 0);
    chk("R1", "pins in reset", {d_o, c_o, r_o}, 3'b111);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    repeat (6) step(1'b0);
    #6;
    chk("R1", "cd_n idle after reset", cd_n, 1);

    // R2/R3: every pattern of active windows, activity at one position per window
    cur_req = "R3";
    for (int mask = 0; mask < 32; mask++) begin
      for (int rep = 0; rep < 2; rep++)
        for (int w = 0; w < M; w++)
          for (int s = 0; s < W; s++)
            step(mask[w] && (s == ((mask + w) % W)));
      cur_req = "R5";
      repeat (H + 3) step(1'b0);
      cur_req = "R3";
    end

    // R2: a single active window in a full history never qualifies
    cur_req = "R2";
    repeat (2 * H) step(1'b0);
    step(1'b1);
    repeat (M * W * 2) step(1'b0);
    #6;
    chk("R2", "one window no carrier", cd_n, 1);

    // R4/R5: gap sweep around the hold limit
    for (int d = 1; d <= H + 2; d++) begin
      cur_req = "R4";
      acquire();
      step(1'b1);
      step(1'b1);
      cur_req = "R5";
      for (int k = 0; k < d; k++) step(1'b0);
      @(negedge clk);
      #6;
      chk(d >= H ? "R5" : "R4", $sformatf("gap %0d", d), cd_n, (d >= H) ? 1 : 0);
      act = 1'b1;
    end

    // R5: after release, history is empty so carrier needs N fresh windows
    cur_req = "R5";
    repeat (H + 2) step(1'b0);
    repeat ((N - 1) * W) step(1'b1);
    #6;
    chk("R5", "no early reacquire", cd_n, 1);

    // R7/R8: mode gating with random pins and bursty activity
    for (int md = 0; md < 2; md++) begin
      cur_req = "R3";
      for (int c = 0; c < 800; c++) begin
        @(negedge clk);
        mode = md[0];
        rxd = 1'($urandom_range(0, 1));
        rxc = 1'($urandom_range(0, 1));
        rxr = 1'($urandom_range(0, 1));
        act = ((c / 60) % 3 != 2) ? (($urandom_range(0, 7)) == 0) : 1'b0;
      end
      repeat (H + 2) step(1'b0);
      @(negedge clk);
      rxd = 0; rxc = 0; rxr = 0;
      #6;
      if (md == 0) chk("R7", "push forced", {d_o, c_o, r_o}, 3'b111);
      else         chk("R8", "host forced", {d_o, c_o, r_o}, 3'b001);
      acquire();
      #1;
      chk(md == 0 ? "R7" : "R8", "pass with carrier", {d_o, c_o, r_o}, 3'b000);
      chk("R6", "enable with carrier", en, 1);
    end

    repeat (H + 2) step(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule